// File: doc/BRIEF.md
# UART Channel Command and Mode Register Controller

This block is the host-facing control slice of a single serial channel inside a multi-channel controller. A byte-wide host bus writes a command register and a shared mode address, and reads back a status byte and the mode register currently selected. The serializer, the FIFOs and the baud generator sit outside the block. They take from it receiver and transmitter enables, one-cycle reset strobes, a break-drive level and the captured framing fields, and they report live ready and empty levels plus error event pulses.

The channel claims an 8-address window whose base is its channel number times eight. Inside the window, offset 0 is the mode address, offset 1 is status (read), and offset 2 is the command register (write). The mode address reaches up to three mode registers through a pointer that moves forward by one step on each write. Commands can set the pointer back to the first or the second register. Receive error indications are sticky and are cleared only by their own command codes.

Top module: `ucr_chan_ctrl`

## Requirements
- R1: Only writes whose address bits above bit 2 equal CHAN_ID affect the channel. Reads outside the window return 0. Inside the window, a read at offset 0 returns the mode register under the pointer, a read at offset 1 returns status, and other offsets return 0.
- R2: A command write with bit 0 set enables the receiver and with bit 1 set disables it. Bit 2 enables the transmitter and bit 3 disables it. When the enable and disable bits for one direction are both set, the disable wins. Both enables are held between commands.
- R3: A command code (bits 7..4) of 2 raises rx_rst_o, and a code of 3 raises tx_rst_o. Each strobe is high for exactly the one cycle after the write edge. The enable bits in bits 3..0 of the same byte still take effect.
- R4: Code 6 sets brk_o high. brk_o stays high until code 7 or code 3 (transmitter reset) is written.
- R5: After reset the pointer selects MR1. A mode write stores into the selected register and then advances the pointer: MR0 moves to MR1, MR1 moves to MR2, and MR2 stays at MR2. Code 1 sets the pointer to MR1.
- R6: Code 0xB sets the pointer to MR0 when HAS_MR0 is 1. When HAS_MR0 is 0, code 0xB acts like code 1 and MR0 reads as 0.
- R7: From MR1, char_bits_o equals 5 plus bits 1..0. Parity is taken from bits 4..2. Code 0 gives par_en_o=1 and par_odd_o=0. Code 1 gives par_en_o=1 and par_odd_o=1. Code 4, and any code with bit 3 or bit 4 set, gives par_en_o=0 and par_odd_o=0. stop_cfg_o carries MR2, ext_cfg_o carries MR0, and mr1_hi_o carries MR1 bits 7..5.
- R8: The status byte puts the live levels in the low four bits: bit 0 is receive ready, bit 1 is FIFO full, bit 2 is transmit ready and bit 3 is transmitter empty.
- R9: Overrun (bit 4), parity error (bit 5) and framing error (bit 6) are set by their event inputs and stay set until code 4 is written. Code 4 leaves bit 7 untouched. An event in the same cycle as the clear leaves the flag set.
- R10: Received break (bit 7) is set by ev_brk and is cleared only by code 5. An event in the same cycle as the clear leaves the flag set.
- R11: While reset is asserted, both enables, both strobes and brk_o are 0. The mode registers and the sticky flags are cleared, and the pointer selects MR1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Host write strobe, one byte per cycle |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| lv_rx_ready | input | 1 | Receive data available (live) |
| lv_fifo_full | input | 1 | Receive FIFO full (live) |
| lv_tx_ready | input | 1 | Transmit holding space available (live) |
| lv_tx_empty | input | 1 | Transmitter fully drained (live) |
| ev_ovr | input | 1 | Overrun event pulse |
| ev_par | input | 1 | Parity error event pulse |
| ev_frm | input | 1 | Framing error event pulse |
| ev_brk | input | 1 | Received break event pulse |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| rx_rst_o | output | 1 | One-cycle receiver reset strobe |
| tx_rst_o | output | 1 | One-cycle transmitter reset strobe |
| brk_o | output | 1 | Drive line to break level |
| char_bits_o | output | 4 | Character length, 5 to 8 |
| par_en_o | output | 1 | Parity bit generated and checked |
| par_odd_o | output | 1 | Odd parity when enabled |
| mr1_hi_o | output | 3 | MR1 bits 7..5 for the datapath |
| stop_cfg_o | output | 8 | MR2 contents |
| ext_cfg_o | output | 8 | MR0 contents (0 when absent) |
| status_o | output | 8 | Status byte |

## Verification
A wrong pointer value stays hidden until the next mode write lands in the wrong register or a read at offset 0 returns the wrong byte. For that reason the bench reads the mode address back often and compares the decoded framing outputs every cycle. A stuck or lost sticky flag appears in status_o on the cycle after the event or the clear. A strobe that lasts too long, or a break level that does not drop on a transmitter reset, appears on the cycle after the command. Two instances, one with MR0 and one without, take the same stimulus, and each is compared against its own model of the pointer.

// File: rtl/ucr_pkg.sv
package ucr_pkg;

  typedef enum logic [1:0] {
    SEL_MR0 = 2'd0,
    SEL_MR1 = 2'd1,
    SEL_MR2 = 2'd2
  } mode_sel_e;

  localparam logic [3:0] OP_SEL_MR1   = 4'h1;
  localparam logic [3:0] OP_RX_RESET  = 4'h2;
  localparam logic [3:0] OP_TX_RESET  = 4'h3;
  localparam logic [3:0] OP_ERR_CLEAR = 4'h4;
  localparam logic [3:0] OP_BRK_CLEAR = 4'h5;
  localparam logic [3:0] OP_BREAK_ON  = 4'h6;
  localparam logic [3:0] OP_BREAK_OFF = 4'h7;
  localparam logic [3:0] OP_SEL_MR0   = 4'hB;

  localparam logic [2:0] OFS_MODE = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CMD  = 3'd2;

  localparam int WIN_BITS = 3;

endpackage

// File: rtl/ucr_cmd_unit.sv
module ucr_cmd_unit
  import ucr_pkg::*;
#(
  parameter bit HAS_MR0 = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  output logic       rx_en_o,
  output logic       tx_en_o,
  output logic       rx_rst_o,
  output logic       tx_rst_o,
  output logic       brk_o,
  output logic       clr_err_o,
  output logic       clr_brk_o,
  output logic       go_mr1_o,
  output logic       go_mr0_o
);

  logic [3:0] op;
  logic       rx_en_q, rx_en_d;
  logic       tx_en_q, tx_en_d;
  logic       rx_rst_q, rx_rst_d;
  logic       tx_rst_q, tx_rst_d;
  logic       brk_q, brk_d;
  logic       hit_mr0;

  assign op      = cmd_byte[7:4];
  assign hit_mr0 = cmd_wr && (op == OP_SEL_MR0);

  always_comb begin
    rx_en_d  = rx_en_q;
    tx_en_d  = tx_en_q;
    brk_d    = brk_q;
    rx_rst_d = 1'b0;
    tx_rst_d = 1'b0;
    if (cmd_wr) begin
      if (cmd_byte[1])      rx_en_d = 1'b0;
      else if (cmd_byte[0]) rx_en_d = 1'b1;
      if (cmd_byte[3])      tx_en_d = 1'b0;
      else if (cmd_byte[2]) tx_en_d = 1'b1;
      rx_rst_d = (op == OP_RX_RESET);
      tx_rst_d = (op == OP_TX_RESET);
      if (op == OP_BREAK_ON)
        brk_d = 1'b1;
      else if ((op == OP_BREAK_OFF) || (op == OP_TX_RESET))
        brk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q  <= 1'b0;
      tx_en_q  <= 1'b0;
      rx_rst_q <= 1'b0;
      tx_rst_q <= 1'b0;
      brk_q    <= 1'b0;
    end else begin
      rx_rst_q <= rx_rst_d;
      tx_rst_q <= tx_rst_d;
      if (cmd_wr) begin
        rx_en_q <= rx_en_d;
        tx_en_q <= tx_en_d;
        brk_q   <= brk_d;
      end
    end
  end

  assign rx_en_o   = rx_en_q;
  assign tx_en_o   = tx_en_q;
  assign rx_rst_o  = rx_rst_q;
  assign tx_rst_o  = tx_rst_q;
  assign brk_o     = brk_q;
  assign clr_err_o = cmd_wr && (op == OP_ERR_CLEAR);
  assign clr_brk_o = cmd_wr && (op == OP_BRK_CLEAR);

  generate
    if (HAS_MR0) begin : g_mr0_cmd
      assign go_mr0_o = hit_mr0;
      assign go_mr1_o = cmd_wr && (op == OP_SEL_MR1);
    end else begin : g_no_mr0_cmd
      assign go_mr0_o = 1'b0;
      assign go_mr1_o = (cmd_wr && (op == OP_SEL_MR1)) || hit_mr0;
    end
  endgenerate

  AST_RX_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_wr && cmd_byte[1]) |-> !rx_en_o) else $error("rx disable lost"); // R2
  AST_TX_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_wr && cmd_byte[3]) |-> !tx_en_o) else $error("tx disable lost"); // R2
  AST_RX_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_o |-> $past(cmd_wr && (cmd_byte[7:4] == OP_RX_RESET))) else $error("stray rx strobe"); // R3
  AST_TX_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_o |-> $past(cmd_wr && (cmd_byte[7:4] == OP_TX_RESET))) else $error("stray tx strobe"); // R3
  AST_BREAK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_wr && ((cmd_byte[7:4] == OP_TX_RESET) || (cmd_byte[7:4] == OP_BREAK_OFF))) |-> !brk_o)
    else $error("break held after stop"); // R4

endmodule

// File: rtl/ucr_mode_bank.sv
module ucr_mode_bank
  import ucr_pkg::*;
#(
  parameter bit HAS_MR0 = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [7:0] wdata,
  input  logic       go_mr1,
  input  logic       go_mr0,
  output logic [7:0] mr0_o,
  output logic [7:0] mr1_o,
  output logic [7:0] mr2_o,
  output logic [7:0] sel_data_o
);

  mode_sel_e  sel_q, sel_d;
  logic       sel_upd;
  logic [7:0] mr1_q, mr2_q;
  logic       wr_mr1, wr_mr2;

  always_comb begin
    sel_d   = sel_q;
    sel_upd = 1'b0;
    if (go_mr0) begin
      sel_d   = SEL_MR0;
      sel_upd = 1'b1;
    end else if (go_mr1) begin
      sel_d   = SEL_MR1;
      sel_upd = 1'b1;
    end else if (mode_wr) begin
      sel_upd = 1'b1;
      case (sel_q)
        SEL_MR0: sel_d = SEL_MR1;
        default: sel_d = SEL_MR2;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SEL_MR1;
    else if (sel_upd) sel_q <= sel_d;
  end

  assign wr_mr1 = mode_wr && (sel_q == SEL_MR1);
  assign wr_mr2 = mode_wr && (sel_q == SEL_MR2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mr1_q <= 8'h00;
    else if (wr_mr1) mr1_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mr2_q <= 8'h00;
    else if (wr_mr2) mr2_q <= wdata;
  end

  generate
    if (HAS_MR0) begin : g_mr0
      logic [7:0] mr0_q;
      logic       wr_mr0;
      assign wr_mr0 = mode_wr && (sel_q == SEL_MR0);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mr0_q <= 8'h00;
        else if (wr_mr0) mr0_q <= wdata;
      end
      assign mr0_o = mr0_q;
    end else begin : g_no_mr0
      assign mr0_o = 8'h00;
    end
  endgenerate

  assign mr1_o = mr1_q;
  assign mr2_o = mr2_q;

  always_comb begin
    case (sel_q)
      SEL_MR0: sel_data_o = mr0_o;
      SEL_MR1: sel_data_o = mr1_q;
      default: sel_data_o = mr2_q;
    endcase
  end

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q != 2'd3) else $error("illegal mode select"); // R5
  AST_MR2_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_wr && !go_mr0 && !go_mr1 && (sel_q == SEL_MR2)) |-> (sel_q == SEL_MR2))
    else $error("select left MR2"); // R5
  AST_MR0_ONLY_WHEN_BUILT: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_MR0 |-> (sel_q != SEL_MR0)) else $error("MR0 selected without MR0"); // R6

endmodule

// File: rtl/ucr_err_flags.sv
module ucr_err_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lv_rx_ready,
  input  logic       lv_fifo_full,
  input  logic       lv_tx_ready,
  input  logic       lv_tx_empty,
  input  logic       ev_ovr,
  input  logic       ev_par,
  input  logic       ev_frm,
  input  logic       ev_brk,
  input  logic       clr_err,
  input  logic       clr_brk,
  output logic [7:0] status_o
);

  // sticky order: [3]=break, [2]=framing, [1]=parity, [0]=overrun
  logic [3:0] stk_q, stk_d;
  logic       stk_upd;

  always_comb begin
    stk_d = stk_q;
    if (clr_err) stk_d[2:0] = 3'b000;
    if (clr_brk) stk_d[3]   = 1'b0;
    stk_d   = stk_d | {ev_brk, ev_frm, ev_par, ev_ovr};
    stk_upd = clr_err | clr_brk | ev_brk | ev_frm | ev_par | ev_ovr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stk_q <= 4'h0;
    else if (stk_upd) stk_q <= stk_d;
  end

  assign status_o = {stk_q, lv_tx_empty, lv_tx_ready, lv_fifo_full, lv_rx_ready};

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(status_o[4] && !clr_err) |-> status_o[4]) else $error("overrun lost"); // R9
  AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_par) |-> status_o[5]) else $error("parity event lost"); // R9
  AST_BRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(status_o[7] && !clr_brk) |-> status_o[7]) else $error("break flag lost"); // R10

endmodule

// File: rtl/ucr_chan_ctrl.sv
module ucr_chan_ctrl
  import ucr_pkg::*;
#(
  parameter int CHAN_ID = 1,
  parameter int ADDR_W  = 6,
  parameter bit HAS_MR0 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              lv_rx_ready,
  input  logic              lv_fifo_full,
  input  logic              lv_tx_ready,
  input  logic              lv_tx_empty,
  input  logic              ev_ovr,
  input  logic              ev_par,
  input  logic              ev_frm,
  input  logic              ev_brk,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              rx_rst_o,
  output logic              tx_rst_o,
  output logic              brk_o,
  output logic [3:0]        char_bits_o,
  output logic              par_en_o,
  output logic              par_odd_o,
  output logic [2:0]        mr1_hi_o,
  output logic [7:0]        stop_cfg_o,
  output logic [7:0]        ext_cfg_o,
  output logic [7:0]        status_o
);

  localparam int CH_W = ADDR_W - WIN_BITS;
  localparam logic [CH_W-1:0] MY_BASE = CH_W'(CHAN_ID);

  logic [2:0] ofs;
  logic       in_win;
  logic       cmd_wr, mode_wr;
  logic       clr_err, clr_brk, go_mr1, go_mr0;
  logic [7:0] mr0, mr1, mr2, sel_data;

  assign ofs     = bus_addr[WIN_BITS-1:0];
  assign in_win  = (bus_addr[ADDR_W-1:WIN_BITS] == MY_BASE);
  assign cmd_wr  = bus_we && in_win && (ofs == OFS_CMD);
  assign mode_wr = bus_we && in_win && (ofs == OFS_MODE);

  ucr_cmd_unit #(.HAS_MR0(HAS_MR0)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_byte  (bus_wdata),
    .rx_en_o   (rx_en_o),
    .tx_en_o   (tx_en_o),
    .rx_rst_o  (rx_rst_o),
    .tx_rst_o  (tx_rst_o),
    .brk_o     (brk_o),
    .clr_err_o (clr_err),
    .clr_brk_o (clr_brk),
    .go_mr1_o  (go_mr1),
    .go_mr0_o  (go_mr0)
  );

  ucr_mode_bank #(.HAS_MR0(HAS_MR0)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .wdata      (bus_wdata),
    .go_mr1     (go_mr1),
    .go_mr0     (go_mr0),
    .mr0_o      (mr0),
    .mr1_o      (mr1),
    .mr2_o      (mr2),
    .sel_data_o (sel_data)
  );

  ucr_err_flags u_err (
    .clk          (clk),
    .rst_n        (rst_n),
    .lv_rx_ready  (lv_rx_ready),
    .lv_fifo_full (lv_fifo_full),
    .lv_tx_ready  (lv_tx_ready),
    .lv_tx_empty  (lv_tx_empty),
    .ev_ovr       (ev_ovr),
    .ev_par       (ev_par),
    .ev_frm       (ev_frm),
    .ev_brk       (ev_brk),
    .clr_err      (clr_err),
    .clr_brk      (clr_brk),
    .status_o     (status_o)
  );

  assign char_bits_o = 4'd5 + {2'b00, mr1[1:0]};
  assign par_en_o    = ~mr1[4] & ~mr1[3];
  assign par_odd_o   = par_en_o & mr1[2];
  assign mr1_hi_o    = mr1[7:5];
  assign stop_cfg_o  = mr2;
  assign ext_cfg_o   = mr0;

  always_comb begin
    bus_rdata = 8'h00;
    if (in_win) begin
      case (ofs)
        OFS_MODE: bus_rdata = sel_data;
        OFS_STAT: bus_rdata = status_o;
        default:  bus_rdata = 8'h00;
      endcase
    end
  end

  AST_FOREIGN_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_we && !in_win) |-> (!rx_rst_o && !tx_rst_o)) else $error("foreign write strobed"); // R1
  AST_FOREIGN_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!in_win || !bus_we) |-> ($stable(rx_en_o) && $stable(tx_en_o) && $stable(brk_o)))
    else $error("control moved without write"); // R1
  AST_CHAR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (char_bits_o >= 4'd5) && (char_bits_o <= 4'd8)) else $error("char length range"); // R7

endmodule

// File: tb/tb_ucr_chan_ctrl.sv
`timescale 1ns/1ps
module tb_ucr_chan_ctrl;

  localparam int CH = 1;
  localparam logic [5:0] A_MODE = 6'd8;
  localparam logic [5:0] A_STAT = 6'd9;
  localparam logic [5:0] A_CMD  = 6'd10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic       bus_we;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       lv_rx, lv_full, lv_trdy, lv_temt;
  logic       e_ovr, e_par, e_frm, e_brk;

  logic [7:0] rd_a, rd_b, st_a, st_b, stop_a, stop_b, ext_a, ext_b;
  logic       rxen_a, txen_a, rxr_a, txr_a, brk_a, pe_a, po_a;
  logic       rxen_b, txen_b, rxr_b, txr_b, brk_b, pe_b, po_b;
  logic [3:0] cb_a, cb_b;
  logic [2:0] hi_a, hi_b;

  ucr_chan_ctrl #(.CHAN_ID(CH), .ADDR_W(6), .HAS_MR0(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_a), .lv_rx_ready(lv_rx), .lv_fifo_full(lv_full), .lv_tx_ready(lv_trdy),
    .lv_tx_empty(lv_temt), .ev_ovr(e_ovr), .ev_par(e_par), .ev_frm(e_frm), .ev_brk(e_brk),
    .rx_en_o(rxen_a), .tx_en_o(txen_a), .rx_rst_o(rxr_a), .tx_rst_o(txr_a), .brk_o(brk_a),
    .char_bits_o(cb_a), .par_en_o(pe_a), .par_odd_o(po_a), .mr1_hi_o(hi_a),
    .stop_cfg_o(stop_a), .ext_cfg_o(ext_a), .status_o(st_a));

  ucr_chan_ctrl #(.CHAN_ID(CH), .ADDR_W(6), .HAS_MR0(1'b0)) dut_nomr0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_b), .lv_rx_ready(lv_rx), .lv_fifo_full(lv_full), .lv_tx_ready(lv_trdy),
    .lv_tx_empty(lv_temt), .ev_ovr(e_ovr), .ev_par(e_par), .ev_frm(e_frm), .ev_brk(e_brk),
    .rx_en_o(rxen_b), .tx_en_o(txen_b), .rx_rst_o(rxr_b), .tx_rst_o(txr_b), .brk_o(brk_b),
    .char_bits_o(cb_b), .par_en_o(pe_b), .par_odd_o(po_b), .mr1_hi_o(hi_b),
    .stop_cfg_o(stop_b), .ext_cfg_o(ext_b), .status_o(st_b));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit       m_rxen, m_txen, m_rxr, m_txr, m_brk;
  int       m_sel, n_sel;
  bit [7:0] m_mr [3];
  bit [7:0] n_mr [3];
  bit [3:0] m_stk;

  function automatic bit [7:0] exp_rd(input int sel, input bit [7:0] r0, input bit [7:0] r1,
                                      input bit [7:0] r2);
    int  chan, o;
    chan = int'(bus_addr) / 8;
    o    = int'(bus_addr) % 8;
    if (chan != CH) return 8'h00;
    if (o == 0) return (sel == 0) ? r0 : (sel == 1) ? r1 : r2;
    if (o == 1) return {m_stk, lv_temt, lv_trdy, lv_full, lv_rx};
    return 8'h00;
  endfunction

  function automatic bit [3:0] exp_len(input bit [7:0] r1);
    return 4'(5 + int'(r1 % 4));
  endfunction

  function automatic bit exp_pe(input bit [7:0] r1);
    int code;
    code = int'(r1 / 4) % 8;
    return (code == 0) || (code == 1);
  endfunction

  function automatic bit exp_po(input bit [7:0] r1);
    int code;
    code = int'(r1 / 4) % 8;
    return (code == 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rxen = 0; m_txen = 0; m_rxr = 0; m_txr = 0; m_brk = 0;
      m_sel = 1; n_sel = 1; m_stk = 0;
      for (int i = 0; i < 3; i++) begin m_mr[i] = 0; n_mr[i] = 0; end
    end else begin
      int  chan, o, op;
      bit  cerr, cbrk;
      chan = int'(bus_addr) / 8;
      o    = int'(bus_addr) % 8;
      op   = int'(bus_wdata) / 16;
      m_rxr = 0; m_txr = 0; cerr = 0; cbrk = 0;
      if (bus_we && chan == CH && o == 2) begin
        if (bus_wdata[1]) m_rxen = 0; else if (bus_wdata[0]) m_rxen = 1;
        if (bus_wdata[3]) m_txen = 0; else if (bus_wdata[2]) m_txen = 1;
        case (op)
          1:  begin m_sel = 1; n_sel = 1; end
          2:  m_rxr = 1;
          3:  begin m_txr = 1; m_brk = 0; end
          4:  cerr = 1;
          5:  cbrk = 1;
          6:  m_brk = 1;
          7:  m_brk = 0;
          11: begin m_sel = 0; n_sel = 1; end
          default: ;
        endcase
      end
      if (bus_we && chan == CH && o == 0) begin
        m_mr[m_sel] = bus_wdata;
        n_mr[n_sel] = bus_wdata;
        m_sel = (m_sel == 0) ? 1 : 2;
        n_sel = (n_sel == 0) ? 1 : 2;
      end
      if (cerr) m_stk[2:0] = 0;
      if (cbrk) m_stk[3] = 0;
      if (e_ovr) m_stk[0] = 1;
      if (e_par) m_stk[1] = 1;
      if (e_frm) m_stk[2] = 1;
      if (e_brk) m_stk[3] = 1;
    end
    #2;
    chk("R2 rx_en", 16'(rxen_a), 16'(m_rxen));
    chk("R2 tx_en", 16'(txen_a), 16'(m_txen));
    chk("R3 rx_rst strobe", 16'(rxr_a), 16'(m_rxr));
    chk("R3 tx_rst strobe", 16'(txr_a), 16'(m_txr));
    chk("R4 break level", 16'(brk_a), 16'(m_brk));
    chk("R1 read data", 16'(rd_a), 16'(exp_rd(m_sel, m_mr[0], m_mr[1], m_mr[2])));
    chk("R6 read data no-MR0", 16'(rd_b), 16'(exp_rd(n_sel, 8'h00, n_mr[1], n_mr[2])));
    chk("R7 char bits", 16'(cb_a), 16'(exp_len(m_mr[1])));
    chk("R7 parity enable", 16'(pe_a), 16'(exp_pe(m_mr[1])));
    chk("R7 parity odd", 16'(po_a), 16'(exp_po(m_mr[1])));
    chk("R7 mr1 high bits", 16'(hi_a), 16'(m_mr[1] / 32));
    chk("R5 MR2 contents", 16'(stop_a), 16'(m_mr[2]));
    chk("R6 MR0 contents", 16'(ext_a), 16'(m_mr[0]));
    chk("R6 MR0 absent", 16'(ext_b), 16'h0);
    chk("R6 no-MR0 char bits", 16'(cb_b), 16'(exp_len(n_mr[1])));
    chk("R9 R10 status", 16'(st_a), 16'({m_stk, lv_temt, lv_trdy, lv_full, lv_rx}));
    chk("R8 status no-MR0", 16'(st_b), 16'(st_a));
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_we = 0; e_ovr = 0; e_par = 0; e_frm = 0; e_brk = 0;
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    e_ovr = 0; e_par = 0; e_frm = 0; e_brk = 0;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic look(input logic [5:0] a);
    @(negedge clk);
    bus_we = 0; bus_addr = a;
  endtask

  task automatic events(input logic [3:0] v);
    @(negedge clk);
    bus_we = 0;
    {e_brk, e_frm, e_par, e_ovr} = v;
    @(negedge clk);
    {e_brk, e_frm, e_par, e_ovr} = 4'h0;
  endtask

  bit done = 0;
  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; bus_we = 0; bus_addr = A_MODE; bus_wdata = 0;
    lv_rx = 0; lv_full = 0; lv_trdy = 0; lv_temt = 0;
    e_ovr = 0; e_par = 0; e_frm = 0; e_brk = 0;
    idle(3);                 // R11 reset state compared every cycle
    rst_n = 1;
    idle(2);
    // R2 enables, disable precedence
    wr(A_CMD, 8'h01); wr(A_CMD, 8'h04); wr(A_CMD, 8'h03); wr(A_CMD, 8'h0C);
    wr(A_CMD, 8'h05); wr(A_CMD, 8'h0A);
    // R3 strobes with enable bits in same byte
    wr(A_CMD, 8'h25); wr(A_CMD, 8'h30);
    @(negedge clk); bus_we = 1; bus_addr = A_CMD; bus_wdata = 8'h20;
    @(negedge clk); bus_wdata = 8'h20;
    @(negedge clk); bus_we = 0;
    // R4 break on / off / tx reset ends break
    wr(A_CMD, 8'h60); idle(2); wr(A_CMD, 8'h70); wr(A_CMD, 8'h60); wr(A_CMD, 8'h30);
    // R1 foreign writes
    wr(6'h02, 8'h65); wr(6'h12, 8'h60); wr(6'h00, 8'hFF); look(6'h01); look(A_MODE + 6'd3);
    // R5 pointer walk
    look(A_MODE);
    wr(A_MODE, 8'h13); wr(A_MODE, 8'h0F); wr(A_MODE, 8'hAA); idle(1);
    wr(A_CMD, 8'h10); wr(A_MODE, 8'hF6); wr(A_CMD, 8'h10); wr(A_MODE, 8'h04);
    wr(A_CMD, 8'h10); wr(A_MODE, 8'h0D); wr(A_CMD, 8'h10); wr(A_MODE, 8'h08);
    // R6 MR0 select
    wr(A_CMD, 8'hB0); wr(A_MODE, 8'h09); wr(A_MODE, 8'h12); wr(A_CMD, 8'hB0); idle(1);
    // R8 live bits
    look(A_STAT);
    lv_rx = 1; idle(1); lv_full = 1; idle(1); lv_trdy = 1; idle(1); lv_temt = 1; idle(1);
    lv_rx = 0; lv_full = 0; idle(1);
    // R9 R10 sticky flags
    events(4'b0001); events(4'b0110); events(4'b1000); idle(2);
    wr(A_CMD, 8'h40); idle(1); look(A_STAT);
    wr(A_CMD, 8'h50); events(4'b1111);
    @(negedge clk); bus_we = 1; bus_addr = A_CMD; bus_wdata = 8'h40; e_par = 1;
    @(negedge clk); bus_we = 0; e_par = 0;
    @(negedge clk); bus_we = 1; bus_addr = A_CMD; bus_wdata = 8'h50; e_brk = 1;
    @(negedge clk); bus_we = 0; e_brk = 0;
    wr(A_CMD, 8'h50); wr(A_CMD, 8'h40); look(A_STAT); idle(1);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      logic [2:0] pick;
      @(negedge clk);
      pick = 3'($urandom_range(0, 7));
      case (pick)
        3'd0, 3'd1: bus_addr = A_CMD;
        3'd2, 3'd3: bus_addr = A_MODE;
        3'd4:       bus_addr = A_STAT;
        3'd5:       bus_addr = A_MODE + 6'd5;
        3'd6:       bus_addr = 6'h02;
        default:    bus_addr = 6'h18;
      endcase
      bus_we    = ($urandom_range(0, 2) != 0);
      bus_wdata = 8'($urandom);
      e_ovr = ($urandom_range(0, 9) == 0);
      e_par = ($urandom_range(0, 9) == 0);
      e_frm = ($urandom_range(0, 9) == 0);
      e_brk = ($urandom_range(0, 9) == 0);
      lv_rx = 1'($urandom); lv_full = 1'($urandom);
      lv_trdy = 1'($urandom); lv_temt = 1'($urandom);
    end
    idle(2);
    // R11 reset mid-run
    rst_n = 0; idle(2); rst_n = 1; look(A_MODE); idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule